// File: doc/BRIEF.md
# Serial-Bus Slave for a Clock/Calendar Register File

This block is a two-wire serial slave that lets a host reach an eight-byte register file. Seven bytes hold the time and date: seconds, minutes, hours, weekday, day of month, century with month, and year. The eighth byte holds the calibration and output control. The bus lines SCL and SDA are sampled by a fast system clock. Each line passes through a synchronizer and a small glitch filter. After that, START and STOP conditions are decoded and every bit is shifted in on a rising SCL edge.

The host writes by sending the device address with the direction bit clear. The first byte after the address sets a three-bit word pointer. Each further byte lands in the register the pointer selects, and the pointer then steps on. The host reads by sending the device address with the direction bit set. The slave then sends bytes starting from the current pointer. This also works without a pointer write first, in which case the read starts wherever the pointer was left. SDA is driven only through an open-drain enable.

The block gives the clock core three things. A hold signal stays high while a time or date byte is being read. A one-cycle write strobe comes with the register index and the masked data. The register file itself supplies the power-on defaults.

Top module: `rtc_bus_slave`

## Requirements
- R1: After reset, SDA is released and the hold output is low. Register 7 reads 80h (output bit 7 high, frequency-test bit 6 low), and registers 0 to 6 read 00h, so the stop bit and the fail-interrupt enable are clear.
- R2: The slave acknowledges an address byte whose upper seven bits are 1101000, that is D0h for a write and D1h for a read. To acknowledge, it holds SDA low through the ninth clock.
- R3: If the address does not match, the slave does not acknowledge it. It then drives nothing and writes nothing until the next START or STOP.
- R4: In a write, the first byte after the address loads the pointer from its bits 2:0. Every later byte is acknowledged and raises `wr_stb_o` for one cycle, with the pointer value on `wr_addr_o`. The pointer then advances by one at the end of the acknowledge clock.
- R5: In a read, the slave sends the byte at the pointer, most significant bit first.
- R6: During a read, the pointer advances only when the host acknowledges. After a host NACK, the slave releases SDA and the pointer keeps its value.
- R7: A read that comes with no pointer write first starts at the pointer left by the previous transfer.
- R8: The pointer wraps from 7 to 0, on both reads and writes.
- R9: Reserved bits always read 0. These are hours bits 7:6, weekday bits 7:3, day-of-month bits 7:6 and month-register bit 5. `wr_data_o` carries the masked value.
- R10: `hold_o` is high only while the slave is sending and the pointer is between 0 and 6. It falls when the pointer reaches 7 or on STOP.
- R11: A repeated START in the middle of a transfer begins a new address phase without a STOP, and the pointer is kept. A STOP returns the slave to idle with SDA released.
- R12: A pulse on SCL or SDA that lasts fewer than `FILT_CYCLES` system clocks has no effect on the bits received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than SCL |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe_o | output | 1 | When 1, pull SDA low (open drain) |
| hold_o | output | 1 | Freeze time-counter updates during a read of the time or date bytes |
| wr_stb_o | output | 1 | One-cycle strobe for each byte written |
| wr_addr_o | output | 3 | Index of the register written |
| wr_data_o | output | 8 | Written value with reserved bits cleared |

## Verification
The register file is loaded through pointer-then-data writes, and the write strobes are compared against a queue filled in advance. Two kinds of read follow. Reads after a repeated START with a fresh pointer show whether the pointer is loaded correctly. Reads with no pointer write, placed after a NACKed byte, show whether the pointer moved on a NACK. Writing all ones to the masked registers shows which bits are reserved. A run that crosses address 7 in both directions shows the wrap. A wrong address followed by extra bytes shows whether the slave keeps quiet. Short glitches on both lines in the middle of a byte show whether the filter rejects them, because an extra clock edge or a false START would corrupt that byte.

// File: rtl/rtc_bus_pkg.sv
package rtc_bus_pkg;
  localparam int unsigned REG_CNT = 8;
  localparam int unsigned PTR_W   = $clog2(REG_CNT);
  localparam logic [6:0]  DEV_ADDR = 7'b1101000;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_PTR, ST_WR, ST_RD, ST_IGN
  } bus_st_e;

  // bits that exist in each register; the rest read as zero
  function automatic logic [7:0] live_bits(input logic [PTR_W-1:0] idx);
    case (idx)
      3'd2:    return 8'h3F;
      3'd3:    return 8'h07;
      3'd4:    return 8'h3F;
      3'd5:    return 8'hDF;
      default: return 8'hFF;
    endcase
  endfunction

  function automatic logic [7:0] por_value(input logic [PTR_W-1:0] idx);
    return (idx == 3'd7) ? 8'h80 : 8'h00;
  endfunction
endpackage

// File: rtl/line_filter.sv
module line_filter #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned FILT_CYCLES = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic line_o
);
  localparam int unsigned CW = $clog2(FILT_CYCLES + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CW-1:0]          cnt_q;
  logic                   out_q;
  logic                   s_w;

  assign s_w = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '1;
    else         sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
  end

  // output follows only after FILT_CYCLES consecutive differing samples
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      out_q <= 1'b1;
    end else if (s_w == out_q) begin
      cnt_q <= '0;
    end else if (cnt_q == CW'(FILT_CYCLES - 1)) begin
      cnt_q <= '0;
      out_q <= s_w;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign line_o = out_q;
endmodule

// File: rtl/bus_framer.sv
module bus_framer (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise_o = !scl_q && scl_i;
  assign scl_fall_o = scl_q && !scl_i;
  assign start_o    = scl_q && scl_i && sda_q && !sda_i;
  assign stop_o     = scl_q && scl_i && !sda_q && sda_i;
endmodule

// File: rtl/reg_bank.sv
module reg_bank
  import rtc_bus_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [PTR_W-1:0] waddr_i,
  input  logic [7:0]       wdata_i,
  input  logic [PTR_W-1:0] raddr_i,
  output logic [7:0]       rdata_o
);
  logic [7:0] regs_q [REG_CNT];

  for (genvar g = 0; g < REG_CNT; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        regs_q[g] <= por_value(PTR_W'(g));
      else if (we_i && waddr_i == PTR_W'(g))
        regs_q[g] <= wdata_i & live_bits(PTR_W'(g));
    end
  end

  assign rdata_o = regs_q[raddr_i];
endmodule

// File: rtl/rtc_bus_slave.sv
module rtc_bus_slave
  import rtc_bus_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned FILT_CYCLES = 3
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe_o,
  output logic       hold_o,
  output logic       wr_stb_o,
  output logic [2:0] wr_addr_o,
  output logic [7:0] wr_data_o
);
  logic scl_f, sda_f, scl_rise, scl_fall, start_w, stop_w;

  line_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT_CYCLES(FILT_CYCLES)) u_scl_filt (
    .clk_i(clk_i), .rst_ni(rst_ni), .line_i(scl_i), .line_o(scl_f));
  line_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT_CYCLES(FILT_CYCLES)) u_sda_filt (
    .clk_i(clk_i), .rst_ni(rst_ni), .line_i(sda_i), .line_o(sda_f));

  bus_framer u_framer (
    .clk_i(clk_i), .rst_ni(rst_ni), .scl_i(scl_f), .sda_i(sda_f),
    .scl_rise_o(scl_rise), .scl_fall_o(scl_fall), .start_o(start_w), .stop_o(stop_w));

  bus_st_e          st_q;
  logic [PTR_W-1:0] ptr_q;
  logic [7:0]       shreg_q, tx_q, rd_data;
  logic [3:0]       cnt_q;
  logic             ack_q, rnw_q, mack_q, oe_q;
  logic             wr_stb_q;
  logic [PTR_W-1:0] wr_addr_q;
  logic [7:0]       wr_data_q;

  reg_bank u_bank (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(wr_stb_q), .waddr_i(wr_addr_q),
    .wdata_i(wr_data_q), .raddr_i(ptr_q), .rdata_o(rd_data));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      ptr_q     <= '0;
      shreg_q   <= '0;
      tx_q      <= '0;
      cnt_q     <= '0;
      ack_q     <= 1'b0;
      rnw_q     <= 1'b0;
      mack_q    <= 1'b0;
      oe_q      <= 1'b0;
      wr_stb_q  <= 1'b0;
      wr_addr_q <= '0;
      wr_data_q <= '0;
    end else begin
      wr_stb_q <= 1'b0;
      if (start_w) begin
        st_q  <= ST_ADDR;
        cnt_q <= '0;
        ack_q <= 1'b0;
        oe_q  <= 1'b0;
      end else if (stop_w) begin
        st_q  <= ST_IDLE;
        ack_q <= 1'b0;
        oe_q  <= 1'b0;
      end else if (scl_rise) begin
        if (!ack_q) begin
          if (st_q inside {ST_ADDR, ST_PTR, ST_WR}) shreg_q <= {shreg_q[6:0], sda_f};
          if (st_q inside {ST_ADDR, ST_PTR, ST_WR, ST_RD}) cnt_q <= cnt_q + 1'b1;
        end else if (st_q == ST_RD) begin
          mack_q <= !sda_f;
          if (!sda_f) ptr_q <= ptr_q + 1'b1;  // advance on host ACK only
        end
      end else if (scl_fall) begin
        if (!ack_q) begin
          if (cnt_q == 4'd8) begin
            case (st_q)
              ST_ADDR: begin
                if (shreg_q[7:1] == DEV_ADDR) begin
                  rnw_q <= shreg_q[0];
                  oe_q  <= 1'b1;
                  ack_q <= 1'b1;
                end else begin
                  st_q <= ST_IGN;
                end
              end
              ST_PTR: begin
                ptr_q <= shreg_q[PTR_W-1:0];
                oe_q  <= 1'b1;
                ack_q <= 1'b1;
              end
              ST_WR: begin
                wr_stb_q  <= 1'b1;
                wr_addr_q <= ptr_q;
                wr_data_q <= shreg_q & live_bits(ptr_q);
                oe_q      <= 1'b1;
                ack_q     <= 1'b1;
              end
              ST_RD: begin
                oe_q  <= 1'b0;
                ack_q <= 1'b1;
              end
              default: ;
            endcase
          end else if (st_q == ST_RD) begin
            oe_q <= !tx_q[6];
            tx_q <= {tx_q[6:0], 1'b0};
          end
        end else begin
          ack_q <= 1'b0;
          cnt_q <= '0;
          oe_q  <= 1'b0;
          case (st_q)
            ST_ADDR: begin
              if (rnw_q) begin
                st_q <= ST_RD;
                tx_q <= rd_data;
                oe_q <= !rd_data[7];
              end else begin
                st_q <= ST_PTR;
              end
            end
            ST_PTR: st_q <= ST_WR;
            ST_WR:  ptr_q <= ptr_q + 1'b1;
            ST_RD: begin
              if (mack_q) begin
                tx_q <= rd_data;
                oe_q <= !rd_data[7];
              end else begin
                st_q <= ST_IGN;
              end
            end
            default: ;
          endcase
        end
      end
    end
  end

  assign sda_oe_o  = oe_q;
  assign hold_o    = (st_q == ST_RD) && (ptr_q != PTR_W'(REG_CNT - 1));
  assign wr_stb_o  = wr_stb_q;
  assign wr_addr_o = wr_addr_q;
  assign wr_data_o = wr_data_q;
endmodule

// File: rtl/rtc_bus_slave_chk.sv
module rtc_bus_slave_chk
  import rtc_bus_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       sda_oe_i,
  input logic       hold_i,
  input logic       wr_stb_i,
  input bus_st_e    st_i,
  input logic [2:0] ptr_i
);
  assert_strobe_single_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stb_i |=> !wr_stb_i);

  assert_no_write_in_read_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stb_i |-> !hold_i);

  assert_ignore_quiet_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i == ST_IGN) |-> !sda_oe_i);

  assert_idle_released_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i == ST_IDLE) |-> !sda_oe_i);

  assert_ptr_step_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ptr_i != $past(ptr_i)) && ($past(st_i) != ST_PTR) |-> (ptr_i == $past(ptr_i) + 3'd1));
endmodule

bind rtc_bus_slave rtc_bus_slave_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .sda_oe_i(sda_oe_o), .hold_i(hold_o),
  .wr_stb_i(wr_stb_o), .st_i(st_q), .ptr_i(ptr_q));

// File: tb/rtc_bus_slave_bench.sv
module rtc_bus_slave_bench;
  localparam int Q = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe, hold, wr_stb;
  logic [2:0] wr_addr;
  logic [7:0] wr_data;
  wire  sda_line = sda_m & !sda_oe;

  int n_chk = 0, n_fail = 0, oe_cnt = 0;
  logic [10:0] exp_wr[$];

  always #2.5 clk = !clk;

  rtc_bus_slave u_rtc_bus_slave (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .hold_o(hold), .wr_stb_o(wr_stb),
    .wr_addr_o(wr_addr), .wr_data_o(wr_data));

  task automatic chk(input string req, input int got, input int exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // scoreboard monitor: pops expected write strobes (R4)
  always @(negedge clk) begin
    if (sda_oe) oe_cnt++;
    if (wr_stb) begin
      n_chk++;
      if (exp_wr.size() == 0) begin
        n_fail++;
        $display("FAIL R4: unexpected strobe addr %0h data %0h expected none", wr_addr, wr_data);
      end else begin
        logic [10:0] e;
        e = exp_wr.pop_front();
        if ({wr_addr, wr_data} !== e) begin
          n_fail++;
          $display("FAIL R4: strobe %0h expected %0h", {wr_addr, wr_data}, e);
        end
      end
    end
  end

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q); sda_m = 1'b0; wq(Q); scl_m = 1'b0; wq(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(Q); scl_m = 1'b1; wq(Q); sda_m = 1'b1; wq(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, input int gl_scl, input int gl_sda,
                           output logic acked);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wq(Q); scl_m = 1'b1; wq(Q / 2);
      if (i == gl_scl) begin scl_m = 1'b0; wq(2); scl_m = 1'b1; end
      if (i == gl_sda) begin sda_m = !b[i]; wq(2); sda_m = b[i]; end
      wq(Q / 2); wq(Q); scl_m = 1'b0; wq(Q);
    end
    sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q); acked = !sda_line; wq(Q); scl_m = 1'b0; wq(Q);
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] b);
    b = '0;
    for (int i = 0; i < 8; i++) begin
      sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q); b = {b[6:0], sda_line}; wq(Q);
      scl_m = 1'b0; wq(Q);
    end
    sda_m = !mack; wq(Q); scl_m = 1'b1; wq(2 * Q); scl_m = 1'b0; wq(Q); sda_m = 1'b1;
  endtask

  task automatic wr(input logic [7:0] b, input string req);
    logic a;
    send_byte(b, -1, -1, a);
    chk(req, a, 1);
  endtask

  task automatic rd(input logic mack, input logic [7:0] exp, input string req);
    logic [7:0] b;
    recv_byte(mack, b);
    chk(req, b, exp);
  endtask

  task automatic set_ptr(input logic [2:0] p);
    bus_start(); wr(8'hD0, "R2"); wr({5'd0, p}, "R4");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    summary();
  end

  initial begin
    logic a;
    wq(5); rst_n = 1'b1; wq(5);
    chk("R1 sda released", sda_oe, 0);
    chk("R1 hold low", hold, 0);

    // R1/R5/R11: defaults read via pointer write + repeated START
    set_ptr(3'd0);
    bus_start(); wr(8'hD1, "R2 read addr");
    for (int i = 0; i < 7; i++) rd(1'b1, 8'h00, "R1 default");
    rd(1'b0, 8'h80, "R1 default reg7");
    bus_stop();

    // R6/R7: NACK kept pointer at 7, current read starts there
    bus_start(); wr(8'hD1, "R7"); rd(1'b0, 8'h80, "R6 R7 current read"); bus_stop();

    // R4 with R9 mask on weekday
    exp_wr.push_back({3'd2, 8'h23});
    exp_wr.push_back({3'd3, 8'h01});
    set_ptr(3'd2); wr(8'h23, "R4"); wr(8'h59, "R4"); bus_stop();

    // R9 reserved bits
    exp_wr.push_back({3'd2, 8'h3F});
    exp_wr.push_back({3'd3, 8'h07});
    exp_wr.push_back({3'd4, 8'h3F});
    exp_wr.push_back({3'd5, 8'hDF});
    set_ptr(3'd2);
    for (int i = 0; i < 4; i++) wr(8'hFF, "R9 write");
    bus_stop();
    set_ptr(3'd2); bus_start(); wr(8'hD1, "R2");
    rd(1'b1, 8'h3F, "R9 hours"); rd(1'b1, 8'h07, "R9 weekday");
    rd(1'b1, 8'h3F, "R9 date");  rd(1'b0, 8'hDF, "R9 month");
    bus_stop();

    // R8 wrap on write and read
    exp_wr.push_back({3'd6, 8'h45});
    exp_wr.push_back({3'd7, 8'h9C});
    exp_wr.push_back({3'd0, 8'h12});
    set_ptr(3'd6); wr(8'h45, "R8"); wr(8'h9C, "R8"); wr(8'h12, "R8 wrap write"); bus_stop();
    set_ptr(3'd7); bus_start(); wr(8'hD1, "R2");
    rd(1'b1, 8'h9C, "R8"); rd(1'b0, 8'h12, "R8 wrap read"); bus_stop();

    // R10 hold
    set_ptr(3'd5); bus_start(); wr(8'hD1, "R2");
    chk("R10 hold at ptr5", hold, 1);
    rd(1'b1, 8'hDF, "R5");
    chk("R10 hold at ptr6", hold, 1);
    rd(1'b1, 8'h45, "R5");
    chk("R10 hold drops at ptr7", hold, 0);
    rd(1'b0, 8'h9C, "R5");
    bus_stop(); wq(Q);
    chk("R10 hold after stop", hold, 0);

    // R3 address mismatch
    oe_cnt = 0;
    bus_start();
    send_byte(8'hA0, -1, -1, a); chk("R3 nack", a, 0);
    send_byte(8'h05, -1, -1, a); chk("R3 ignored byte", a, 0);
    send_byte(8'h77, -1, -1, a); chk("R3 ignored byte", a, 0);
    bus_stop();
    chk("R3 sda never driven", oe_cnt, 0);
    bus_start(); wr(8'hD1, "R3 recovers"); rd(1'b0, 8'h9C, "R3 R7 pointer kept"); bus_stop();

    // R12 glitches on SCL and SDA inside a data byte
    exp_wr.push_back({3'd1, 8'h5A});
    set_ptr(3'd1);
    send_byte(8'h5A, 3, 5, a); chk("R12 ack", a, 1);
    bus_stop();
    set_ptr(3'd1); bus_start(); wr(8'hD1, "R2"); rd(1'b0, 8'h5A, "R12 readback"); bus_stop();

    // R11 repeated START in mid write
    exp_wr.push_back({3'd3, 8'h04});
    set_ptr(3'd3); wr(8'h04, "R11");
    bus_start(); wr(8'hD1, "R11"); rd(1'b0, 8'h3F, "R11 repeated start read");
    bus_stop(); wq(Q);
    chk("R11 released after stop", sda_oe, 0);

    chk("R4 all strobes seen", exp_wr.size(), 0);
    summary();
  end
endmodule